// File: doc/BRIEF.md
# Packed Bucket Fetch and Match Engine

This engine serves one lookup per request. A request carries a bucket number and a 24-bit search key. The engine reads that bucket from an external memory that is 72 bits wide. It rebuilds the 40-bit entries packed inside the bucket and returns the 16-bit output port of the matching entry. When no entry matches, it reports a miss.

A bucket holds a fixed number of entries, set by the `SLOTS` parameter. The entries are packed end to end with no padding, so some of them cross the boundary between two memory words. The engine keeps the words of the bucket that is arriving, and compares every entry once the final word of the bucket is present. While one bucket is being compared, the reads for the next request are already running. Results come out in the order the requests were accepted.

Top module: `bucket_fetch_match`

## Requirements
- R1: While reset is held and directly after it, `res_valid` and `mem_rd_en` are low and `req_ready` is high.
- R2: Each accepted request issues exactly BEATS = ceil(40*SLOTS/72) reads, one per cycle with no gaps, starting in the cycle after acceptance. With the default `SLOTS`=4 this is 3 reads.
- R3: The reads of one bucket use consecutive word addresses in ascending order.
- R4: The first read address of a bucket is the bucket number multiplied by BEATS.
- R5: Word b of a bucket supplies bits [72b+71:72b] of the bucket bit string. Entry i occupies bits [40i+39:40i] of that string, which can place it across two words. Within an entry, bits [39:16] hold the prefix and bits [15:0] hold the port.
- R6: An entry hits when its prefix equals the key on all 24 bits and its port is nonzero. An entry whose port is zero is empty and never hits.
- R7: When several entries hit, the port of the entry with the lowest index is returned.
- R8: On a miss, `res_hit` is 0 and `res_port` is 0.
- R9: Results leave in request order. Each result is valid for one cycle, in the cycle after the final read data of its bucket arrives.
- R10: A request that is waiting is accepted in the same cycle as the final read of the previous bucket. The reads of consecutive requests therefore form one continuous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lookup request is present |
| req_ready | output | 1 | The engine can take a request this cycle |
| req_id | input | ID_W | Bucket number |
| req_key | input | 24 | Search key |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | 72 | Read data word |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A matching entry was found |
| res_port | output | 16 | Port of the winning entry, or 0 on a miss |

## Verification
A wrong read counter or a wrong base address shows up on `mem_addr` in the same cycle as the faulty read. A receive-side beat count that drifts from the data moves the result strobe, or pairs the result with the key of another request. That appears at the first result after the fault, and every result after it follows the wrong order. Faults in unpacking the entries, for example a slice offset by a few bits, only show when the key belongs to an entry that crosses a word boundary. For that reason the lookups aim at entries 1 and 3, which both straddle two words, as well as at duplicate prefixes and empty entries.

// File: rtl/bucket_fetch_match.sv
module bucket_fetch_match #(
  parameter int SLOTS  = 4,
  parameter int ID_W   = 8,
  parameter int ADDR_W = 16,
  parameter int KQ     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [23:0]       req_key,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd_valid,
  input  logic [71:0]       mem_rd_data,
  output logic              res_valid,
  output logic              res_hit,
  output logic [15:0]       res_port
);
  localparam int ENTRY_W = 40;
  localparam int WORD_W  = 72;
  localparam int BEATS   = (ENTRY_W*SLOTS + WORD_W - 1) / WORD_W;
  localparam int BW      = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int KW      = (KQ > 1) ? $clog2(KQ) : 1;

  logic              busy;
  logic [BW-1:0]     ibeat;
  logic [ADDR_W-1:0] base;
  logic [BW-1:0]     rbeat;
  logic [WORD_W-1:0] wbuf [BEATS];
  logic [23:0]       kq [KQ];
  logic [KW-1:0]     wptr, rptr;
  logic [KW:0]       kcnt;

  logic last_issue, req_fire, pop;
  logic [BEATS*WORD_W-1:0] bucket;
  logic        hit_n;
  logic [15:0] port_n;

  assign last_issue = busy && (ibeat == BW'(BEATS-1));
  assign req_ready  = (!busy || last_issue) && (kcnt != (KW+1)'(KQ));
  assign req_fire   = req_valid && req_ready;
  assign pop        = mem_rd_valid && (rbeat == BW'(BEATS-1));
  assign mem_rd_en  = busy;
  assign mem_addr   = base + ADDR_W'(ibeat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ibeat <= '0;
      base  <= '0;
    end else if (req_fire) begin
      busy  <= 1'b1;
      ibeat <= '0;
      base  <= ADDR_W'(req_id) * ADDR_W'(BEATS);
    end else if (busy) begin
      ibeat <= ibeat + 1'b1;
      if (last_issue) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      kcnt <= '0;
    end else begin
      if (req_fire) wptr <= (wptr == KW'(KQ-1)) ? '0 : wptr + 1'b1;
      if (pop)      rptr <= (rptr == KW'(KQ-1)) ? '0 : rptr + 1'b1;
      kcnt <= kcnt + (KW+1)'(req_fire) - (KW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (req_fire) kq[wptr] <= req_key;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rbeat <= '0;
    else if (mem_rd_valid) rbeat <= pop ? '0 : rbeat + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (mem_rd_valid) wbuf[rbeat] <= mem_rd_data;
  end

  always_comb begin
    for (int b = 0; b < BEATS; b++)
      bucket[b*WORD_W +: WORD_W] = (rbeat == BW'(b)) ? mem_rd_data : wbuf[b];
  end

  always_comb begin
    hit_n  = 1'b0;
    port_n = '0;
    for (int i = SLOTS-1; i >= 0; i--) begin
      if (bucket[i*ENTRY_W+16 +: 24] == kq[rptr] && bucket[i*ENTRY_W +: 16] != 16'h0) begin
        hit_n  = 1'b1;
        port_n = bucket[i*ENTRY_W +: 16];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_port  <= '0;
    end else begin
      res_valid <= pop;
      if (pop) begin
        res_hit  <= hit_n;
        res_port <= port_n;
      end
    end
  end
endmodule

// File: rtl/bucket_fetch_match_chk.sv
module bucket_fetch_match_chk #(
  parameter int SLOTS  = 4,
  parameter int ID_W   = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ID_W-1:0]   req_id,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_valid,
  input logic              res_valid,
  input logic              res_hit,
  input logic [15:0]       res_port
);
  localparam int BEATS = (40*SLOTS + 71) / 72;

  logic fire;
  int owed, pend;
  logic [ADDR_W-1:0] exp_base;
  logic just_fired;

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= 0;
      pend <= 0;
      just_fired <= 1'b0;
      exp_base <= '0;
    end else begin
      owed <= owed + (fire ? BEATS : 0) - (mem_rd_en ? 1 : 0);
      pend <= pend + (fire ? 1 : 0) - (res_valid ? 1 : 0);
      just_fired <= fire;
      if (fire) exp_base <= ADDR_W'(req_id) * ADDR_W'(BEATS);
    end
  end

  a_r2_read_owed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> owed > 0);
  a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_en |-> owed == 0);
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !just_fired) |-> mem_addr == $past(mem_addr) + 1'b1);
  a_r4_base_addr: assert property (@(posedge clk) disable iff (!rst_n)
    just_fired |-> (mem_rd_en && mem_addr == exp_base));
  a_r6_hit_port: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> res_port != 16'h0);
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_port == 16'h0);
  a_r9_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_rd_valid));
  a_r9_result_owed: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> pend > 0);
endmodule

bind bucket_fetch_match bucket_fetch_match_chk #(.SLOTS(SLOTS), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
  .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port));

// File: tb/bucket_fetch_match_tb.sv
module bucket_fetch_match_tb;
  localparam int SLOTS = 4;
  localparam int BEATS = (40*SLOTS + 71) / 72;
  localparam int NV    = 12;
  localparam logic [6:0] VEC [NV] = '{
    {4'd0, 3'd0}, {4'd0, 3'd3}, {4'd1, 3'd1}, {4'd2, 3'd1},
    {4'd3, 3'd2}, {4'd5, 3'd0}, {4'd4, 3'd4}, {4'd7, 3'd2},
    {4'd15, 3'd3}, {4'd9, 3'd1}, {4'd15, 3'd0}, {4'd6, 3'd4}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_id = '0;
  logic [23:0] req_key = '0;
  logic mem_rd_en, mem_rd_valid, res_valid, res_hit;
  logic [15:0] mem_addr, res_port;
  logic [71:0] mem_rd_data;

  always #2 clk = ~clk;

  bucket_fetch_match #(.SLOTS(SLOTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_key(req_key), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port));

  logic [71:0] mem [64];
  logic [23:0] sp [16][SLOTS];
  logic [15:0] pp [16][SLOTS];

  always_ff @(posedge clk) begin
    mem_rd_valid <= rst_n && mem_rd_en;
    mem_rd_data  <= mem[mem_addr[5:0]];
  end

  int checks = 0, fails = 0, cyc = 0;
  int nsent = 0, nres = 0, nrd = 0;
  int acc_id [64];
  logic exp_hit [64];
  logic [15:0] exp_port [64];
  int rd_cyc [64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_rd_en) begin
      chk(mem_addr == 16'(acc_id[nrd/BEATS]*BEATS + nrd%BEATS), "R3/R4 read address",
          mem_addr, acc_id[nrd/BEATS]*BEATS + nrd%BEATS);
      rd_cyc[nrd] = cyc;
      nrd++;
    end
    if (res_valid) begin
      chk(res_hit == exp_hit[nres] && res_port == exp_port[nres], "R5/R6/R7/R8/R9 result",
          {res_hit, res_port}, {exp_hit[nres], exp_port[nres]});
      nres++;
    end
  end

  task automatic pack();
    for (int b = 0; b < 16; b++) begin
      logic [BEATS*72-1:0] v = '0;
      for (int i = 0; i < SLOTS; i++) v[i*40 +: 40] = {sp[b][i], pp[b][i]};
      for (int w = 0; w < BEATS; w++) mem[b*BEATS + w] = v[w*72 +: 72];
    end
  endtask

  task automatic send(input int id, input logic [23:0] key);
    logic h = 1'b0;
    logic [15:0] p = '0;
    for (int i = SLOTS-1; i >= 0; i--)
      if (sp[id][i] == key && pp[id][i] != 0) begin h = 1'b1; p = pp[id][i]; end
    acc_id[nsent] = id;
    exp_hit[nsent] = h;
    exp_port[nsent] = p;
    nsent++;
    req_valid = 1'b1;
    req_id = 8'(id);
    req_key = key;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", nres, nsent);
    finish_run();
  end

  initial begin
    for (int a = 0; a < 64; a++) mem[a] = '0;
    for (int b = 0; b < 16; b++)
      for (int i = 0; i < SLOTS; i++) begin
        sp[b][i] = 24'hA00000 ^ 24'(b*24'h1357) ^ 24'(i*24'h2468B);
        pp[b][i] = 16'(16'h0100 + b*4 + i);
      end
    sp[2][3] = sp[2][1];
    pp[3][2] = 16'h0;
    sp[5][0] = sp[5][2];
    pp[5][0] = 16'h0;
    pack();
    repeat (3) @(negedge clk);
    chk(!res_valid && !mem_rd_en && req_ready, "R1 in reset", {res_valid, mem_rd_en, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid && !mem_rd_en && req_ready, "R1 after reset", {res_valid, mem_rd_en, req_ready}, 3'b001);
    for (int v = 0; v < NV; v++) begin
      int id = int'(VEC[v][6:3]);
      int sel = int'(VEC[v][2:0]);
      send(id, (sel < SLOTS) ? sp[id][sel] : 24'hFFFFFF);
    end
    while (nres < nsent) @(negedge clk);
    chk(rd_cyc[NV*BEATS-1] - rd_cyc[0] == NV*BEATS-1, "R10 continuous reads",
        rd_cyc[NV*BEATS-1] - rd_cyc[0], NV*BEATS-1);
    repeat (5) @(negedge clk);
    send(11, sp[11][3]);
    repeat (8) @(negedge clk);
    chk(nrd == nsent*BEATS, "R2 read count", nrd, nsent*BEATS);
    chk(nres == nsent, "R9 result count", nres, nsent);
    finish_run();
  end
endmodule